// File: doc/BRIEF.md
# Bus-Clock Watchdog with Lock-After-First-Write Options

This block is a free-running watchdog counter driven by the bus clock. If software does not service it within the selected period, it raises a system reset request. Software services the watchdog by writing to a fixed service address. The data on that write is discarded, so the value written does not matter.

Two option bits set the watchdog's behaviour: an enable and a period select. Both live in an options register that accepts exactly one write after each reset and then stays fixed until the next reset. This keeps a runaway program from switching the watchdog off or stretching its period. After any reset the watchdog is enabled with the longer period.

A shift parameter divides both periods by the same power of two, so that a simulation can reach timeouts quickly. The reset sequencer that consumes the request, and the clock generation, sit outside this block.

Top module: `wdog_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, `opt_en` is 1, `opt_long` is 1, `rst_req` is 0 and `svc_pulse` is 0.
- R2: The first write to `OPT_ADDR` after reset loads the options from the write data: bit 7 becomes `opt_en` and bit 6 becomes `opt_long` (1 = long period). The new values appear on the outputs in the cycle after the write edge.
- R3: Every later write to `OPT_ADDR` is ignored until the next reset. After a reset, the register accepts one new write again.
- R4: A first write that carries the default values (enable 1, long 1) still uses up the single allowed write, so a later write cannot change the options.
- R5: A write of any data to `SVC_ADDR` produces a one-cycle `svc_pulse` in the next cycle and restarts the count from zero. It changes neither option bit and does not use up the options write.
- R6: With the long period selected and no service, `rst_req` rises exactly 2^(20-SCALE_SHIFT) clock edges after the reset release or after the edge that follows the service pulse.
- R7: With the short period selected, the timeout is 2^(18-SCALE_SHIFT) edges, counted the same way.
- R8: `rst_req` is high for exactly one cycle. After it, the counter holds at zero and no further request occurs until reset, even when services arrive.
- R9: When `opt_en` is 0, `rst_req` never asserts and the counter stays at zero.
- R10: Writes to any address other than `SVC_ADDR` and `OPT_ADDR` change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| svc_pulse | output | 1 | One-cycle pulse after a write to the service address |
| rst_req | output | 1 | One-cycle system reset request on timeout |
| opt_en | output | 1 | Current watchdog enable |
| opt_long | output | 1 | Current period select (1 = long) |

## Verification
The assertions assume that `wr_en`, `wr_addr` and `wr_data` are stable around each rising edge and that reset is applied before any checked behaviour. They also assume that the period select does not shrink while the count is already past the short limit. The bench drives every input on falling edges and starts each scenario from a fresh reset. It writes the options only in the first cycles after reset, so the count never runs beyond the period that is selected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Positions of the option fields within a write to the options address
  localparam int OPT_EN_BIT   = 7;
  localparam int OPT_LONG_BIT = 6;

  typedef struct packed {
    logic en;
    logic long_sel;
  } wdog_opt_t;

  localparam wdog_opt_t OPT_DEFAULT = '{en: 1'b1, long_sel: 1'b1};
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'h11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               svc_pulse,
  output logic               opt_wr,
  output wdog_pkg::wdog_opt_t opt_wdata
);
  import wdog_pkg::*;

  logic svc_hit;
  logic unused_data;

  assign svc_hit  = wr_en && (wr_addr == SVC_ADDR);
  assign opt_wr   = wr_en && (wr_addr == OPT_ADDR);
  assign opt_wdata.en       = wr_data[OPT_EN_BIT];
  assign opt_wdata.long_sel = wr_data[OPT_LONG_BIT];
  assign unused_data = ^wr_data;

  // Service data is discarded: only the address hit is registered
  always_ff @(posedge clk) begin
    if (rst) svc_pulse <= 1'b0;
    else     svc_pulse <= svc_hit;
  end

  assert_svc_single_R5: assert property (@(posedge clk) disable iff (rst)
    svc_pulse |-> $past(wr_en));
endmodule

// File: rtl/wdog_optreg.sv
module wdog_optreg (
  input  logic                clk,
  input  logic                rst,
  input  logic                opt_wr,
  input  wdog_pkg::wdog_opt_t opt_wdata,
  output wdog_pkg::wdog_opt_t opt_q
);
  import wdog_pkg::*;

  logic locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q  <= OPT_DEFAULT;
      locked <= 1'b0;
    end else if (opt_wr && !locked) begin
      opt_q  <= opt_wdata;
      locked <= 1'b1;
    end
  end

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(opt_q));
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int SHORT_LOG2  = 18,
  parameter int LONG_LOG2   = 20,
  parameter int SCALE_SHIFT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic long_sel,
  input  logic svc,
  output logic req
);
  localparam int SHORT_EXP = SHORT_LOG2 - SCALE_SHIFT;
  localparam int LONG_EXP  = LONG_LOG2 - SCALE_SHIFT;
  localparam int CW        = LONG_EXP + 1;
  localparam logic [CW-1:0] LAST_SHORT = CW'((64'd1 << SHORT_EXP) - 64'd1);
  localparam logic [CW-1:0] LAST_LONG  = CW'((64'd1 << LONG_EXP) - 64'd1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          tripped;

  assign last = long_sel ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tripped <= 1'b0;
      req     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (!en || tripped) begin
        cnt <= '0;
      end else if (svc) begin
        cnt <= '0;
      end else if (cnt >= last) begin
        cnt     <= '0;
        tripped <= 1'b1;
        req     <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_req_single_R8: assert property (@(posedge clk) disable iff (rst)
    req |=> !req);
  assert_tripped_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (tripped && !req) |=> !req);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!req && cnt == '0));
  assert_svc_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (svc && en) |=> cnt == '0);
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_LONG);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] OPT_ADDR = 8'h11,
  parameter int SHORT_LOG2  = 18,
  parameter int LONG_LOG2   = 20,
  parameter int SCALE_SHIFT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              svc_pulse,
  output logic              rst_req,
  output logic              opt_en,
  output logic              opt_long
);
  import wdog_pkg::*;

  logic      opt_wr;
  wdog_opt_t opt_wdata;
  wdog_opt_t opt_q;

  wdog_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .OPT_ADDR(OPT_ADDR)
  ) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .svc_pulse(svc_pulse), .opt_wr(opt_wr), .opt_wdata(opt_wdata)
  );

  wdog_optreg u_opt (
    .clk(clk), .rst(rst), .opt_wr(opt_wr), .opt_wdata(opt_wdata), .opt_q(opt_q)
  );

  wdog_counter #(
    .SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2), .SCALE_SHIFT(SCALE_SHIFT)
  ) u_cnt (
    .clk(clk), .rst(rst), .en(opt_q.en), .long_sel(opt_q.long_sel),
    .svc(svc_pulse), .req(rst_req)
  );

  assign opt_en   = opt_q.en;
  assign opt_long = opt_q.long_sel;

  assert_reset_defaults_R1: assert property (@(posedge clk)
    $past(rst) |-> (opt_en && opt_long && !rst_req && !svc_pulse));
endmodule

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;
  localparam int SHIFT = 12;
  localparam int LSHORT = 1 << (18 - SHIFT);
  localparam int LLONG  = 1 << (20 - SHIFT);
  localparam logic [7:0] SVC = 8'h10;
  localparam logic [7:0] OPT = 8'h11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic svc_pulse, rst_req, opt_en, opt_long;
  int n_checks = 0;
  int n_fails = 0;

  always #4 clk = ~clk;

  wdog_guard #(.SVC_ADDR(SVC), .OPT_ADDR(OPT), .SCALE_SHIFT(SHIFT)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .svc_pulse(svc_pulse), .rst_req(rst_req), .opt_en(opt_en), .opt_long(opt_long)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Returns at the falling edge after the write edge
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 en", opt_en, 1); check("R1 long", opt_long, 1);
    check("R1 req", rst_req, 0); check("R1 svc", svc_pulse, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 en after release", opt_en, 1);
    check("R1 req after release", rst_req, 0);
  endtask

  task automatic t_long_and_single();
    int seen;
    do_reset();
    repeat (LLONG - 1) @(posedge clk);
    @(negedge clk); check("R6 long no early req", rst_req, 0);
    @(posedge clk); @(negedge clk); check("R6 long req", rst_req, 1);
    @(posedge clk); @(negedge clk); check("R8 req one cycle", rst_req, 0);
    seen = 0;
    for (int i = 0; i < 2 * LLONG; i++) begin
      if (i % 50 == 0) bus_write(SVC, 8'hA5);
      else begin @(posedge clk); @(negedge clk); end
      if (rst_req) seen++;
    end
    check("R8 no repeat request", seen, 0);
  endtask

  task automatic t_short();
    do_reset();
    bus_write(OPT, 8'h80);
    check("R2 long cleared", opt_long, 0); check("R2 en kept", opt_en, 1);
    repeat (LSHORT - 2) @(posedge clk);
    @(negedge clk); check("R7 short no early req", rst_req, 0);
    @(posedge clk); @(negedge clk); check("R7 short req", rst_req, 1);
  endtask

  task automatic t_lock();
    do_reset();
    bus_write(OPT, 8'h80);
    bus_write(OPT, 8'hC0);
    check("R3 long locked", opt_long, 0);
    bus_write(OPT, 8'h00);
    check("R3 en locked", opt_en, 1);
    do_reset();
    check("R3 defaults back", opt_long, 1);
    bus_write(OPT, 8'h00);
    check("R3 rearmed write", opt_en, 0);
  endtask

  task automatic t_disabled();
    int seen = 0;
    do_reset();
    bus_write(OPT, 8'h00);
    for (int i = 0; i < 2 * LLONG + 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) seen++;
    end
    check("R9 no request disabled", seen, 0);
  endtask

  task automatic t_default_lock();
    do_reset();
    bus_write(OPT, 8'hC0);
    bus_write(OPT, 8'h00);
    check("R4 en stays", opt_en, 1); check("R4 long stays", opt_long, 1);
  endtask

  task automatic t_service();
    int seen = 0;
    do_reset();
    repeat (100) @(posedge clk);
    @(negedge clk);
    bus_write(SVC, 8'h00);
    check("R5 svc pulse", svc_pulse, 1);
    check("R5 data ignored", opt_en, 1);
    @(posedge clk); @(negedge clk); check("R5 pulse one cycle", svc_pulse, 0);
    for (int i = 0; i < 4 * LLONG; i++) begin
      if (i % (LLONG / 2) == 0) bus_write(SVC, 8'hFF);
      else begin @(posedge clk); @(negedge clk); end
      if (rst_req) seen++;
    end
    check("R5 servicing prevents timeout", seen, 0);
    // Last service was i = 3*LLONG+LLONG/2; measure from a fresh one
    bus_write(SVC, 8'h3C);
    repeat (LLONG) @(posedge clk);
    @(negedge clk); check("R6 after service no early req", rst_req, 0);
    @(posedge clk); @(negedge clk); check("R6 after service req", rst_req, 1);
    do_reset();
    bus_write(SVC, 8'h00);
    bus_write(OPT, 8'h80);
    check("R5 lock not consumed", opt_long, 0);
  endtask

  task automatic t_other_addr();
    do_reset();
    bus_write(8'h55, 8'h00);
    check("R10 en unchanged", opt_en, 1); check("R10 long unchanged", opt_long, 1);
    check("R10 no svc pulse", svc_pulse, 0);
    bus_write(OPT, 8'h80);
    check("R10 opt write still open", opt_long, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_long_and_single();
    t_short();
    t_lock();
    t_default_lock();
    t_disabled();
    t_service();
    t_other_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule